// File: doc/BRIEF.md
# Function-Coded Arithmetic and Logic Unit

This block is the combinational arithmetic and logic stage of a small accumulator machine. Two data operands, A and B, enter together with a four-bit function code. In the same cycle the block returns a result of the operand width and four status flags: zero, carry, negative and overflow. The enclosing datapath latches the result and the flags if it needs them.

Three functions are arithmetic: addition, subtraction A minus B and reverse subtraction B minus A. All three share one carry chain. The other functions are passing either operand through unchanged, AND, OR and XOR, and inverting either operand. A function code with no operation assigned still gives a defined output, so control logic may emit any code without producing undefined data.

Top module: `alu_core`

## Requirements
- R1: Function code 0 (add) yields (A + B) modulo 2^W. C is the carry out of the top bit. V is set when A and B have the same sign and the result has the other sign.
- R2: Function code 1 yields (A - B) modulo 2^W. C is 1 when A >= B as unsigned numbers, meaning no borrow. V is set when A and B differ in sign and the result's sign differs from A.
- R3: Function code 2 yields (B - A) modulo 2^W. C is 1 when B >= A as unsigned numbers. V is set when A and B differ in sign and the result's sign differs from B.
- R4: Function code 3 outputs A unchanged and function code 4 outputs B unchanged.
- R5: Function codes 5, 6 and 7 output the bitwise AND, OR and XOR of A and B.
- R6: Function code 8 outputs the bitwise inverse of A and function code 9 outputs the bitwise inverse of B.
- R7: For every function code, Z is 1 exactly when the result is all zeros, and N equals the result's most significant bit.
- R8: Function codes 10 to 15 output a result of zero with Z = 1 and C, N and V all 0.
- R9: Function codes 3 to 9 always drive C and V to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W (8) | Operand A |
| b_i | input | W (8) | Operand B |
| func_i | input | 4 | Function code |
| res_o | output | W (8) | Result |
| flag_z_o | output | 1 | Result is zero |
| flag_c_o | output | 1 | Carry out, or no borrow for subtraction |
| flag_n_o | output | 1 | Result sign bit |
| flag_v_o | output | 1 | Signed overflow |

## Verification
The bench uses the default width of 8. At that width an operand is small enough to cover every edge of the carry chain directly. Every function code is applied to every pair drawn from a corner set: 0x00, 0x01, 0x7F, 0x80, 0x81, 0xFE, 0xFF and 0x55. This set reaches the signed wrap at 0x7F/0x80, the borrow at equal operands and the all-ones carry ripple for all three arithmetic functions. A run of random operands and codes follows, and every result is compared with a behavioural model written with integer arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 8;
    localparam int FUNC_W = 4;

    typedef enum logic [FUNC_W-1:0] {
        F_ADD   = 4'd0,
        F_SUB   = 4'd1,
        F_RSUB  = 4'd2,
        F_PASSA = 4'd3,
        F_PASSB = 4'd4,
        F_AND   = 4'd5,
        F_OR    = 4'd6,
        F_XOR   = 4'd7,
        F_NOTA  = 4'd8,
        F_NOTB  = 4'd9
    } func_e;

    typedef enum logic [1:0] {
        CL_ARITH  = 2'd0,
        CL_LOGIC  = 2'd1,
        CL_UNUSED = 2'd2
    } class_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } flags_t;

    function automatic class_e func_class(input logic [FUNC_W-1:0] f);
        if (f <= 4'd2)      return CL_ARITH;
        else if (f <= 4'd9) return CL_LOGIC;
        else                return CL_UNUSED;
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [FUNC_W-1:0] func,
    output logic [W-1:0]      sum,
    output logic              carry,
    output logic              ovf
);
    localparam int MSB = W - 1;

    logic         do_sub;
    logic         do_rsub;
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [W:0]   cy;

    // Pick which operand is the minuend and invert the other one.
    always_comb begin
        do_sub  = (func == F_SUB);
        do_rsub = (func == F_RSUB);
        x       = do_rsub ? b : a;
        if (do_sub)       y = ~b;
        else if (do_rsub) y = ~a;
        else              y = b;
    end

    assign cy[0] = do_sub | do_rsub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = x[i] ^ y[i] ^ cy[i];
        assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
    end

    assign carry = cy[W];
    assign ovf   = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [FUNC_W-1:0] func,
    output logic [W-1:0]      res
);
    always_comb begin
        unique case (func)
            F_PASSA: res = a;
            F_PASSB: res = b;
            F_AND:   res = a & b;
            F_OR:    res = a | b;
            F_XOR:   res = a ^ b;
            F_NOTA:  res = ~a;
            F_NOTB:  res = ~b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] res,
    input  class_e       cls,
    input  logic         arith_c,
    input  logic         arith_v,
    output flags_t       flags
);
    always_comb begin
        flags.z = ~|res;
        flags.n = res[W-1];
        flags.c = (cls == CL_ARITH) ? arith_c : 1'b0;
        flags.v = (cls == CL_ARITH) ? arith_v : 1'b0;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [FUNC_W-1:0] func_i,
    output logic [W-1:0]      res_o,
    output logic              flag_z_o,
    output logic              flag_c_o,
    output logic              flag_n_o,
    output logic              flag_v_o
);
    class_e       cls;
    logic [W-1:0] arith_res;
    logic [W-1:0] logic_res;
    logic         arith_c;
    logic         arith_v;
    flags_t       flags;

    assign cls = func_class(func_i);

    alu_arith #(.W(W)) u_arith (
        .a(a_i), .b(b_i), .func(func_i),
        .sum(arith_res), .carry(arith_c), .ovf(arith_v)
    );

    alu_logic #(.W(W)) u_logic (
        .a(a_i), .b(b_i), .func(func_i), .res(logic_res)
    );

    always_comb begin
        unique case (cls)
            CL_ARITH: res_o = arith_res;
            CL_LOGIC: res_o = logic_res;
            default:  res_o = '0;
        endcase
    end

    alu_flags #(.W(W)) u_flags (
        .res(res_o), .cls(cls), .arith_c(arith_c), .arith_v(arith_v),
        .flags(flags)
    );

    assign flag_z_o = flags.z;
    assign flag_c_o = flags.c;
    assign flag_n_o = flags.n;
    assign flag_v_o = flags.v;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [3:0]   func_i,
    input logic [W-1:0] res_o,
    input logic         flag_z_o,
    input logic         flag_c_o,
    input logic         flag_n_o,
    input logic         flag_v_o
);
    logic [W:0] wide_sum;
    assign wide_sum = {1'b0, a_i} + {1'b0, b_i};

    always_comb begin
        if (!$isunknown({a_i, b_i, func_i})) begin
            assert_zero_flag_R7: assert (flag_z_o == (res_o == '0));
            assert_neg_flag_R7: assert (flag_n_o == res_o[W-1]);
            if (func_i == 4'd0)
                assert_add_R1: assert ({flag_c_o, res_o} == wide_sum);
            if (func_i == 4'd1)
                assert_sub_borrow_R2: assert (flag_c_o == (a_i >= b_i));
            if (func_i == 4'd2)
                assert_rsub_borrow_R3: assert (flag_c_o == (b_i >= a_i));
            if (func_i == 4'd3)
                assert_pass_a_R4: assert (res_o == a_i);
            if (func_i >= 4'd3 && func_i <= 4'd9)
                assert_logic_clears_R9: assert (!flag_c_o && !flag_v_o);
            if (func_i >= 4'd10)
                assert_unused_code_R8: assert (res_o == '0 && flag_z_o
                                               && !flag_c_o && !flag_n_o && !flag_v_o);
        end
    end
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
    .a_i(a_i), .b_i(b_i), .func_i(func_i), .res_o(res_o),
    .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
    .flag_n_o(flag_n_o), .flag_v_o(flag_v_o)
);

// File: tb/tb_alu_core.sv
`timescale 1ns/1ps
module tb_alu_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a = 8'h00;
    logic [7:0] b = 8'h00;
    logic [3:0] fn = 4'd0;
    logic [7:0] res;
    logic       fz, fc, fn_flag, fv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    alu_core dut (
        .a_i(a), .b_i(b), .func_i(fn), .res_o(res),
        .flag_z_o(fz), .flag_c_o(fc), .flag_n_o(fn_flag), .flag_v_o(fv)
    );

    function automatic string req_of(int f);
        case (f)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3, 4: return "R4/R9";
            5, 6, 7: return "R5/R9";
            8, 9: return "R6/R9";
            default: return "R8";
        endcase
    endfunction

    // Behavioural model: returns {res, z, c, n, v}
    function automatic logic [11:0] model(int f, int x, int y);
        int r = 0;
        int c = 0;
        int v = 0;
        int sx = x >= 128 ? x - 256 : x;
        int sy = y >= 128 ? y - 256 : y;
        int sr;
        case (f)
            0: begin r = x + y; c = r >= 256 ? 1 : 0; sr = sx + sy; end
            1: begin r = x - y; c = x >= y ? 1 : 0;  sr = sx - sy; end
            2: begin r = y - x; c = y >= x ? 1 : 0;  sr = sy - sx; end
            3: r = x;
            4: r = y;
            5: r = x & y;
            6: r = x | y;
            7: r = x ^ y;
            8: r = ~x;
            9: r = ~y;
            default: r = 0;
        endcase
        if (f <= 2) v = (sr > 127 || sr < -128) ? 1 : 0;
        r = r & 255;
        return {r[7:0], (r == 0), c[0], r[7], v[0]};
    endfunction

    task automatic apply(int f, int x, int y, string tag);
        logic [11:0] exp;
        logic [11:0] act;
        @(posedge clk);
        fn = f[3:0];
        a  = x[7:0];
        b  = y[7:0];
        @(negedge clk);
        exp = model(f, x, y);
        act = {res, fz, fc, fn_flag, fv};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s) func=%0d a=%02h b=%02h: actual res=%02h zcnv=%04b expected res=%02h zcnv=%04b",
                     tag, req_of(f), f, x, y, act[11:4], act[3:0], exp[11:4], exp[3:0]);
        end
    endtask

    initial begin
        int corner[8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h55};
        repeat (3) @(posedge clk);
        // Reset state: zero operands on add give zero with Z set (R7, R1)
        @(negedge clk);
        checks++;
        if ({res, fz, fc, fn_flag, fv} !== 12'b0000_0000_1000) begin
            fails++;
            $display("FAIL reset R7: actual res=%02h zcnv=%b%b%b%b expected res=00 zcnv=1000",
                     res, fz, fc, fn_flag, fv);
        end
        rst = 1'b0;
        // Every code over corner pairs: R1..R9
        for (int f = 0; f < 16; f++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(f, corner[i], corner[j], "corner");
        // Named boundaries
        apply(0, 8'hFF, 8'h01, "R1 carry wrap");
        apply(0, 8'h7F, 8'h01, "R1 signed overflow");
        apply(1, 8'h80, 8'h01, "R2 signed overflow");
        apply(1, 8'h10, 8'h10, "R2 equal no borrow");
        apply(2, 8'h01, 8'h80, "R3 signed overflow");
        apply(2, 8'h20, 8'h10, "R3 borrow");
        apply(15, 8'hFF, 8'hFF, "R8 unused code");
        // Random sweep
        for (int k = 0; k < 3000; k++)
            apply(int'($urandom_range(15)), int'($urandom_range(255)),
                  int'($urandom_range(255)), "random");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule